// File: doc/BRIEF.md
# Aligned Mixed-Length Instruction Fetch

This block sits between instruction memory and the decoder of a core that has no compressed instructions. It reads naturally aligned 64-bit words from memory, one request at a time, and delivers whole instructions to the decoder. An instruction is either a 32-bit base instruction or a 64-bit extension instruction. The two low bits of an instruction's first 32-bit parcel give its length. The value `11` means 32 bits. Any other value means 64 bits.

A 64-bit instruction must start on an 8-byte boundary, so it never straddles two memory words. Code generators place a 32-bit NOP before it where needed to reach that boundary. If a 64-bit length code turns up in the upper half of a word, the block raises a misalignment fault. It then stops delivering until a redirect arrives. A redirect from branch resolution loads a new PC, discards the buffered word and any read still in flight, and resumes at the aligned word. It begins with the upper half when PC bit 2 is set.

Top module: `aligned_fetch_unit`

## Requirements
- R1: A parcel whose bits [1:0] equal `11` is offered as a 32-bit instruction. `out_len64` is 0, `out_instr[31:0]` holds the parcel and `out_instr[63:32]` is zero.
- R2: A parcel in the lower half of a word (PC bit 2 = 0) whose bits [1:0] differ from `11` is offered as a 64-bit instruction. `out_len64` is 1, `out_instr` holds the whole memory word and `out_pc[2:0]` is zero.
- R3: Each memory word is read once. Both 32-bit halves of a word are served from that single read, the lower half (bits [31:0]) before the upper half (bits [63:32]).
- R4: A 64-bit length code in the upper half raises `fault_misalign` with `out_pc` equal to the parcel's address. No instruction is offered, and the fault holds until a redirect.
- R5: `out_pc` is the byte address of the offered instruction. After a handshake it advances by 4 for a 32-bit instruction and by 8 for a 64-bit instruction.
- R6: While `out_valid` is high and `out_ready` is low, `out_instr`, `out_len64` and `out_pc` hold steady and the PC does not advance.
- R7: During a redirect cycle, no instruction or fault is offered. After it, the buffered word is discarded and fetch restarts at `redirect_pc` with bits [1:0] cleared. When bit 2 is set, the lower half of that word is skipped.
- R8: A memory response to a read issued before a redirect is dropped and never reaches the output.
- R9: Out of reset, nothing is offered and the first read requests the word at `RESET_PC`.
- R10: A 32-bit NOP (`0x00000013`) used as padding in an upper half is offered as an ordinary 32-bit instruction. The 64-bit instruction that follows is delivered from the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Load a new fetch PC this cycle |
| redirect_pc | input | PC_W | Target of the redirect |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | PC_W | 8-byte aligned read address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Returned memory word |
| out_valid | output | 1 | Instruction offered to decoder |
| out_ready | input | 1 | Decoder takes the instruction |
| out_instr | output | 64 | Instruction bits, zero-extended when 32-bit |
| out_len64 | output | 1 | 1 = 64-bit instruction, 0 = 32-bit |
| out_pc | output | PC_W | Address of the offered instruction or faulting parcel |
| fault_misalign | output | 1 | Misaligned 64-bit instruction detected |

## Verification
With a one-cycle memory, a read goes out in the cycle after a redirect clock edge and its data lands at the second edge after it. The first instruction or fault is therefore visible during the third cycle. A second parcel from the same word follows one cycle after the first one's handshake. A fault is visible in the same cycle as the word that causes it. The scoreboard does not count cycles; it compares each expected item in the cycle the handshake or fault is visible. The monitor samples 2 ns after each falling edge, after the driver's 1 ns input changes, so a redirect or stall is already seen for the coming edge. The stall check compares the offered item against the one seen one cycle earlier.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int PARCEL_W = 32;
  localparam int WORD_W   = 64;

  // Length rule: only code 2'b11 in the first parcel means a 32-bit instruction.
  function automatic logic code_is_long(input logic [1:0] code);
    return code != 2'b11;
  endfunction

  // Byte distance to the next instruction.
  function automatic logic [3:0] pc_step(input logic is_long);
    return is_long ? 4'd8 : 4'd4;
  endfunction
endpackage

// File: rtl/fetch_pc_track.sv
module fetch_pc_track #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect_valid,
  input  logic [PC_W-1:0] redirect_pc,
  input  logic            adv,
  input  logic            adv_long,
  output logic [PC_W-1:0] pc
);
  import fetch_pkg::*;

  localparam logic [PC_W-1:0] PARCEL_MASK = ~PC_W'(3);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pc_q <= RESET_PC & PARCEL_MASK;
    else if (redirect_valid) pc_q <= redirect_pc & PARCEL_MASK;
    else if (adv)            pc_q <= pc_q + PC_W'(pc_step(adv_long));
  end

  assign pc = pc_q;

  // R5: step by instruction length after a handshake
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !redirect_valid && adv_long) |=> (pc_q == $past(pc_q) + PC_W'(8)));
  assert_pc_step_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !redirect_valid && !adv_long) |=> (pc_q == $past(pc_q) + PC_W'(4)));
  // R6: no advance without a handshake or redirect
  assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !redirect_valid) |=> $stable(pc_q));
endmodule

// File: rtl/fetch_mem_port.sv
module fetch_mem_port #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc,
  input  logic            need_word,
  input  logic            redirect_valid,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [PC_W-1:0] req_addr,
  input  logic            rsp_valid,
  output logic            load,
  output logic            drop_o
);
  localparam logic [PC_W-1:0] WORD_MASK = ~PC_W'(7);

  logic pend_q, drop_q;
  logic req_fire, rsp_take;

  assign req_valid = rst_n && need_word && !pend_q && !redirect_valid;
  assign req_addr  = pc & WORD_MASK;
  assign req_fire  = req_valid && req_ready;
  assign rsp_take  = rsp_valid && pend_q;
  assign load      = rsp_take && !drop_q && !redirect_valid;
  assign drop_o    = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (rsp_take) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
      end else if (req_fire) begin
        pend_q <= 1'b1;
      end
      if (redirect_valid && pend_q && !rsp_valid) drop_q <= 1'b1;
    end
  end

  // R3: a new read only after the previous one returned
  assert_one_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid);
endmodule

// File: rtl/fetch_word_buf.sv
module fetch_word_buf #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              consume_last,
  output logic              buf_valid,
  output logic [WORD_W-1:0] buf_data
);
  logic              valid_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
    end else if (consume_last) begin
      valid_q <= 1'b0;
    end
  end

  assign buf_valid = valid_q;
  assign buf_data  = data_q;

  // R6: word contents only change on a fresh load
  assert_word_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !load) |=> $stable(data_q));
endmodule

// File: rtl/fetch_slicer.sv
module fetch_slicer (
  input  logic        buf_valid,
  input  logic [63:0] buf_data,
  input  logic        upper_half,
  input  logic        redirect_valid,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [63:0] out_instr,
  output logic        out_len64,
  output logic        misalign,
  output logic        fire,
  output logic        consume_last
);
  import fetch_pkg::*;

  logic [PARCEL_W-1:0] parcel;
  logic                is_long;

  assign parcel       = upper_half ? buf_data[63:32] : buf_data[31:0];
  assign is_long      = code_is_long(parcel[1:0]);
  assign misalign     = buf_valid && is_long && upper_half && !redirect_valid;
  assign out_valid    = buf_valid && !(is_long && upper_half) && !redirect_valid;
  assign out_len64    = is_long;
  assign out_instr    = is_long ? buf_data : {32'b0, parcel};
  assign fire         = out_valid && out_ready;
  assign consume_last = fire && (is_long || upper_half);
endmodule

// File: rtl/aligned_fetch_unit.sv
module aligned_fetch_unit #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect_valid,
  input  logic [PC_W-1:0] redirect_pc,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [PC_W-1:0] req_addr,
  input  logic            rsp_valid,
  input  logic [63:0]     rsp_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [63:0]     out_instr,
  output logic            out_len64,
  output logic [PC_W-1:0] out_pc,
  output logic            fault_misalign
);
  import fetch_pkg::*;

  logic [PC_W-1:0]   pc_w;
  logic              buf_valid_w, load_w, drop_w;
  logic [WORD_W-1:0] buf_data_w;
  logic              fire_w, consume_last_w, misalign_w;

  fetch_pc_track #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .adv(fire_w), .adv_long(out_len64), .pc(pc_w)
  );

  fetch_mem_port #(.PC_W(PC_W)) u_port (
    .clk(clk), .rst_n(rst_n), .pc(pc_w), .need_word(!buf_valid_w),
    .redirect_valid(redirect_valid),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .load(load_w), .drop_o(drop_w)
  );

  fetch_word_buf #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(redirect_valid),
    .load(load_w), .load_data(rsp_data), .consume_last(consume_last_w),
    .buf_valid(buf_valid_w), .buf_data(buf_data_w)
  );

  fetch_slicer u_slice (
    .buf_valid(buf_valid_w), .buf_data(buf_data_w), .upper_half(pc_w[2]),
    .redirect_valid(redirect_valid), .out_ready(out_ready),
    .out_valid(out_valid), .out_instr(out_instr), .out_len64(out_len64),
    .misalign(misalign_w), .fire(fire_w), .consume_last(consume_last_w)
  );

  assign out_pc         = pc_w;
  assign fault_misalign = misalign_w;

  // R1: short instructions carry the 11 code and a zero upper half
  assert_short_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_len64) |-> (out_instr[1:0] == 2'b11 && out_instr[63:32] == 32'b0));
  // R2: long instructions only from an 8-byte boundary
  assert_long_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len64) |-> (out_pc[2:0] == 3'b000));
  // R4: fault persists until a redirect
  assert_fault_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_misalign |=> (fault_misalign || redirect_valid));
  // R6: a stalled offer holds
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (redirect_valid ||
      (out_valid && $stable(out_instr) && $stable(out_pc) && $stable(out_len64))));
  // R7: redirect empties the word buffer
  assert_redirect_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !buf_valid_w);
  // R8: a stale response never fills the buffer
  assert_stale_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_w && rsp_valid && !buf_valid_w) |=> !buf_valid_w);
endmodule

// File: tb/tb_aligned_fetch_unit.sv
module tb_aligned_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        out_valid, out_ready = 1'b0;
  logic [63:0] out_instr;
  logic        out_len64;
  logic [31:0] out_pc;
  logic        fault_misalign;

  always #5 clk = ~clk;

  aligned_fetch_unit #(.PC_W(32), .RESET_PC(32'h0)) dut (
    .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_len64(out_len64), .out_pc(out_pc), .fault_misalign(fault_misalign)
  );

  int checks = 0, errors = 0;
  int cyc = 0;

  // memory model
  logic [63:0] mem [0:31];
  logic [31:0] raddr = '0;
  int lat = 1, cnt = 0, reqs = 0;
  assign req_ready = 1'b1;
  assign rsp_valid = (cnt == 1);
  assign rsp_data  = mem[raddr[7:3]];

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (req_valid && req_ready) begin
      raddr <= req_addr; cnt <= lat; reqs <= reqs + 1;
    end else if (cnt != 0) cnt <= cnt - 1;
  end

  // scoreboard
  logic [63:0] q_instr[$];
  logic [31:0] q_pc[$];
  logic        q_len[$];
  logic        q_fault[$];
  string       q_tag[$];
  bit gate = 0, stall_mode = 0, first_pending = 0;
  string first_tag = "R7";
  bit hold_chk = 0;
  logic [63:0] h_instr;
  logic [31:0] h_pc;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // expected items computed from the length rule
  task automatic scan(input logic [31:0] start, input int maxn);
    logic [31:0] pc = start;
    for (int n = 0; n < maxn; n++) begin
      logic [63:0] w = mem[pc[7:3]];
      logic [31:0] p = pc[2] ? w[63:32] : w[31:0];
      if (p[1:0] == 2'b11) begin
        q_instr.push_back({32'b0, p}); q_pc.push_back(pc); q_len.push_back(1'b0);
        q_fault.push_back(1'b0); q_tag.push_back(p == 32'h13 ? "R10" : "R1");
        pc = pc + 4;
      end else if (pc[2]) begin
        q_instr.push_back('0); q_pc.push_back(pc); q_len.push_back(1'b0);
        q_fault.push_back(1'b1); q_tag.push_back("R4");
        break;
      end else begin
        q_instr.push_back(w); q_pc.push_back(pc); q_len.push_back(1'b1);
        q_fault.push_back(1'b0); q_tag.push_back("R2");
        pc = pc + 8;
      end
    end
  endtask

  task automatic pop();
    void'(q_instr.pop_front()); void'(q_pc.pop_front()); void'(q_len.pop_front());
    void'(q_fault.pop_front()); void'(q_tag.pop_front());
    if (q_pc.size() == 0) gate = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (rst_n) begin
      out_ready = gate && (!stall_mode || (cyc % 3 != 1));
      if (hold_chk && !redirect_valid) begin
        check(out_valid && out_instr == h_instr && out_pc == h_pc, "R6 stall hold",
              {out_pc, out_instr[31:0]}, {h_pc, h_instr[31:0]});
      end
      if (out_valid && fault_misalign)
        check(1'b0, "R4 instruction offered with fault", 64'(out_pc), 64'h0);
      if (gate && out_valid && out_ready) begin
        if (q_fault[0]) begin
          check(1'b0, "R4 expected fault, got instruction", 64'(out_pc), 64'(q_pc[0]));
          pop();
        end else begin
          string ptag = first_pending ? first_tag : "R5";
          first_pending = 0;
          check(out_pc == q_pc[0], ptag, 64'(out_pc), 64'(q_pc[0]));
          check(out_instr == q_instr[0] && out_len64 == q_len[0], q_tag[0],
                out_instr, q_instr[0]);
          pop();
        end
      end else if (gate && fault_misalign) begin
        check(q_fault[0] && out_pc == q_pc[0], "R4 fault", 64'(out_pc), 64'(q_pc[0]));
        first_pending = 0;
        pop();
      end
      hold_chk = out_valid && !out_ready;
      h_instr = out_instr;
      h_pc = out_pc;
    end else begin
      check(!out_valid && !fault_misalign, "R9 idle in reset", 64'(out_valid), 64'h0);
    end
  end

  task automatic pulse(input logic [31:0] a);
    @(negedge clk); #1;
    redirect_valid = 1'b1; redirect_pc = a;
    @(negedge clk); #1;
    redirect_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && gate; i++) @(negedge clk);
    #3;
    if (gate) begin
      check(1'b0, "scoreboard not drained", 64'(q_pc.size()), 64'h0);
      gate = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      mem[i] = {8'(2*i+1), 22'h2345, 2'b11, 8'(2*i), 22'h1234, 2'b11};
    mem[1] = 64'hCAFE_0001_BEEF_0001;        // long, code 01
    mem[2] = {32'h0000_0013, 32'h1111_2223}; // short + NOP padding
    mem[3] = 64'h5555_6666_7777_8880;        // long, code 00
    mem[4] = 64'h9999_AAAA_BBBB_CCC2;        // long, code 10
    mem[5] = {32'hDEAD_0001, 32'h4444_0007}; // short + misaligned long
    mem[6] = {32'h6000_00A7, 32'h6000_00B1}; // lower long, upper short
    mem[7] = 64'h7070_7070_0123_4561;

    // scenario 1 from reset: R1, R2, R10, R4, R3, stalls
    scan(32'h0, 20);
    gate = 1; stall_mode = 1; first_pending = 1; first_tag = "R9";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(req_valid && req_addr == 32'h0, "R9 first read", 64'(req_addr), 64'h0);
    drain();
    check(reqs == 6, "R3 one read per word", 64'(reqs), 64'd6);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #3;
      check(fault_misalign && !out_valid && out_pc == 32'd44, "R4 fault holds",
            64'(out_pc), 64'd44);
    end

    // scenario 2: redirect into an upper half
    stall_mode = 0; lat = 1;
    scan(32'd52, 6);
    gate = 1; first_pending = 1; first_tag = "R7";
    pulse(32'd54);
    drain();

    // scenario 3: redirect while a slow read is pending
    lat = 4;
    scan(32'd124, 4);
    gate = 1; first_pending = 1; first_tag = "R8";
    pulse(32'd80);
    pulse(32'd124);
    drain();

    // scenario 4: long instructions with stalls ending in a fault
    begin
      int base;
      lat = 2; stall_mode = 1;
      scan(32'd24, 20);
      gate = 1; first_pending = 1; first_tag = "R7";
      base = reqs;
      pulse(32'd24);
      drain();
      check(reqs - base == 3, "R3 one read per word", 64'(reqs - base), 64'd3);
    end
    finish_run();
  end
endmodule